// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This block holds two independent up-counting timer channels behind a small register bus with 16-bit words. Each channel divides the peripheral clock by a power of two that software selects. It counts the divided ticks in a 16-bit counter. When the counter equals the channel's compare value, the counter returns to zero and counting goes on. If the channel has its interrupt enabled, it also raises a one-clock pulse on its own interrupt output. A single shared run register turns each channel's counting on or off.

Software programs a channel by setting its compare value, its divider and its interrupt enable, and then sets the channel's run bit. The interrupt outputs give a periodic event with a period of (compare + 1) × divisor clocks. The counter can be read live at any time, and it can be overwritten.

The bus is word-addressed, so `bus_addr` is the byte offset divided by two. Word 0 is the run register. Channel 0 uses words 1 (control), 2 (counter) and 3 (compare). Channel 1 uses words 4 (control), 5 (counter) and 6 (compare). Word 7 is unmapped. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled, and it holds until the next read.

Top module: `cmatch_timer`

## Requirements
- R1: After reset, the run register, both control registers and both counters read 0, and both compare registers read 0xFFFF.
- R2: Registers sit at the word addresses given above: run register at 0, channel 0 at 1/2/3 and channel 1 at 4/5/6, each as control/counter/compare.
- R3: In the run register, bit 0 runs channel 0 and bit 1 runs channel 1. All other bits read as 0.
- R4: In a control register, bits [1:0] are the divider select and bit 6 is the interrupt enable. All other bits read as 0.
- R5: Divider select values 0, 1, 2 and 3 advance the counter once every 8, 32, 128 and 512 clocks. While a channel is stopped its prescaler is held at zero, so the first count after a start arrives one full divisor later.
- R6: When a running channel's counter equals its compare value at a tick, the counter becomes 0 and keeps counting from there.
- R7: Each compare match drives the channel's interrupt output high for exactly one clock, but only when the channel's interrupt enable is 1. With the enable at 0 there is no pulse, but the counter still clears.
- R8: While a channel's run bit is 0, its counter keeps its value and no match or interrupt occurs, even when the counter equals the compare value.
- R9: A software write to the counter takes priority over an increment or a match-clear in the same cycle. That cycle produces no match and no interrupt.
- R10: Reads of word 7 return 0, and writes to it change no register.
- R11: A counter read returns the counter value in the cycle in which `bus_rd` is sampled, including while the channel runs. The data appears one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address (byte offset / 2) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after a read |
| irq_o | output | 2 | Per-channel one-clock compare-match interrupt pulses |

## Verification
The hardest case to reach from the ports is a software counter write that lands on the very clock edge where a match would occur, since that edge is fixed by the prescaler phase. The bench starts the channel from a known stopped state, which puts its prescaler at zero. It then counts edges from the run-register write and places the counter write exactly on the 32nd edge. It checks that the interrupt is pushed out by the length of a later period. The same edge counting is used to restart a channel after a stop partway through a prescale period, which shows that no leftover prescaler phase shortens the first tick.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int START_WORD = 0;
  localparam int WORDS_PER_CH = 3;
  localparam int CKS_W = 2;
  localparam int IE_BIT = 6;
  localparam int DIV_EXP_BASE = 3;
  localparam int DIV_EXP_STEP = 2;
  localparam int DIV_EXP_MAX = DIV_EXP_BASE + DIV_EXP_STEP * ((1 << CKS_W) - 1);

  typedef enum logic [1:0] {
    RK_CTL = 2'd0,
    RK_CNT = 2'd1,
    RK_COR = 2'd2
  } reg_kind_e;

  function automatic int word_of(input int ch, input reg_kind_e k);
    return 1 + WORDS_PER_CH * ch + int'(k);
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);
  localparam int PRE_W = DIV_EXP_MAX;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] div_m1;

  always_comb begin
    div_m1 = PRE_W'((1 << (DIV_EXP_BASE + DIV_EXP_STEP * int'(cks))) - 1);
    tick   = run && (pre_q >= div_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  // R5: a stopped channel leaves its prescaler at zero
  p_pre_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pre_q == '0));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ctl_we,
  input  logic          cnt_we,
  input  logic          cor_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_rd,
  output logic [DW-1:0] cnt_rd,
  output logic [DW-1:0] cor_rd,
  output logic          irq
);
  logic [CKS_W-1:0] cks_q;
  logic             ie_q;
  logic [DW-1:0]    cnt_q;
  logic [DW-1:0]    cor_q;
  logic             irq_q;
  logic             tick;
  logic             match;

  cmt_prescaler u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .cks  (cks_q),
    .tick (tick)
  );

  assign match = tick && (cnt_q == cor_q) && !cnt_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      cks_q <= '0;
      ie_q  <= 1'b0;
      cnt_q <= '0;
      cor_q <= '1;
      irq_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        cks_q <= wdata[CKS_W-1:0];
        ie_q  <= wdata[IE_BIT];
      end
      if (cor_we) cor_q <= wdata;
      if (cnt_we)     cnt_q <= wdata;
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
      irq_q <= match && ie_q;
    end
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[CKS_W-1:0] = cks_q;
    ctl_rd[IE_BIT] = ie_q;
  end

  assign cnt_rd = cnt_q;
  assign cor_rd = cor_q;
  assign irq    = irq_q;

  // R8: stopped and not written -> counter frozen
  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt_q));
  // R6: a match at a tick clears the counter
  p_clear_on_match_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && cnt_q == cor_q) |=> (cnt_q == '0));
  // R9: software write always lands
  p_sw_wins_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(wdata)));
  // R7: single-clock pulse
  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R7: pulse only with enable set
  p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(ie_q));
  // R8: no pulse follows a stopped cycle
  p_irq_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(run));
endmodule

// File: rtl/cmt_regmap.sv
module cmt_regmap
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 16,
  parameter int AW     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [AW-1:0]              bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  input  logic [NUM_CH-1:0][DW-1:0]  ctl_rd,
  input  logic [NUM_CH-1:0][DW-1:0]  cnt_rd,
  input  logic [NUM_CH-1:0][DW-1:0]  cor_rd,
  output logic [NUM_CH-1:0]          run,
  output logic [NUM_CH-1:0]          ctl_we,
  output logic [NUM_CH-1:0]          cnt_we,
  output logic [NUM_CH-1:0]          cor_we,
  output logic [DW-1:0]              bus_rdata
);
  logic [NUM_CH-1:0] start_q;
  logic [DW-1:0]     rmux;
  logic [DW-1:0]     rdata_q;
  logic [NUM_CH-1:0] hit_ch;
  logic              hit;
  logic              start_sel;

  assign start_sel = (int'(bus_addr) == START_WORD);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic sel_ctl, sel_cnt, sel_cor;
    assign sel_ctl   = (int'(bus_addr) == word_of(c, RK_CTL));
    assign sel_cnt   = (int'(bus_addr) == word_of(c, RK_CNT));
    assign sel_cor   = (int'(bus_addr) == word_of(c, RK_COR));
    assign ctl_we[c] = bus_wr && sel_ctl;
    assign cnt_we[c] = bus_wr && sel_cnt;
    assign cor_we[c] = bus_wr && sel_cor;
    assign hit_ch[c] = sel_ctl || sel_cnt || sel_cor;
  end

  assign hit = start_sel || (|hit_ch);

  always_comb begin
    rmux = '0;
    if (start_sel) rmux[NUM_CH-1:0] = start_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(bus_addr) == word_of(c, RK_CTL)) rmux = ctl_rd[c];
      if (int'(bus_addr) == word_of(c, RK_CNT)) rmux = cnt_rd[c];
      if (int'(bus_addr) == word_of(c, RK_COR)) rmux = cor_rd[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && start_sel) start_q <= bus_wdata[NUM_CH-1:0];
      if (bus_rd) rdata_q <= rmux;
    end
  end

  assign run       = start_q;
  assign bus_rdata = rdata_q;

  // R10: unmapped reads return zero
  p_unmapped_read_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> (bus_rdata == '0));
  // R10: unmapped writes leave the run register alone
  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit) |=> $stable(start_q));
  // R3: run register readback has no stray bits
  p_start_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && start_sel) |=> ((bus_rdata >> NUM_CH) == '0));
endmodule

// File: rtl/cmatch_timer.sv
module cmatch_timer
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 16,
  parameter int AW     = $clog2(1 + WORDS_PER_CH * NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0]         run;
  logic [NUM_CH-1:0]         ctl_we, cnt_we, cor_we;
  logic [NUM_CH-1:0][DW-1:0] ctl_rd, cnt_rd, cor_rd;

  cmt_regmap #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_map (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctl_rd    (ctl_rd),
    .cnt_rd    (cnt_rd),
    .cor_rd    (cor_rd),
    .run       (run),
    .ctl_we    (ctl_we),
    .cnt_we    (cnt_we),
    .cor_we    (cor_we),
    .bus_rdata (bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cmt_channel #(.DW(DW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run[c]),
      .ctl_we (ctl_we[c]),
      .cnt_we (cnt_we[c]),
      .cor_we (cor_we[c]),
      .wdata  (bus_wdata),
      .ctl_rd (ctl_rd[c]),
      .cnt_rd (cnt_rd[c]),
      .cor_rd (cor_rd[c]),
      .irq    (irq_o[c])
    );
  end
endmodule

// File: tb/cmatch_timer_bench.sv
`timescale 1ns/1ps
module cmatch_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt0 = 0;
  int irq_cnt1 = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  cmatch_timer u_cmatch_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wait_irq(input int ch, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(posedge clk); #1;
      n++;
      if (irq_o[ch]) break;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        item_t it;
        #2;
        it = sb_q.pop_front();
        check(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (irq_o[0]) irq_cnt0++;
    if (irq_o[1]) irq_cnt1++;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n, base0, base1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(irq_o == 2'b00, "R1 irq idle", irq_o, 0);

    // R1 / R2 reset values at each word address
    rd_exp(0, 16'h0000, "R1 run reg");
    rd_exp(1, 16'h0000, "R1 ctl0");
    rd_exp(2, 16'h0000, "R1 cnt0");
    rd_exp(3, 16'hFFFF, "R1 cor0");
    rd_exp(4, 16'h0000, "R1 ctl1");
    rd_exp(5, 16'h0000, "R1 cnt1");
    rd_exp(6, 16'hFFFF, "R1 cor1");

    // R2 / R4 control fields
    wr(1, 16'hFFFF); rd_exp(1, 16'h0043, "R4 ctl0 mask");
    wr(4, 16'h0002); rd_exp(4, 16'h0002, "R4 ctl1 cks");
    wr(6, 16'h00AB); rd_exp(6, 16'h00AB, "R2 cor1 word");
    rd_exp(3, 16'hFFFF, "R2 cor0 untouched");
    wr(1, 16'h0000); wr(4, 16'h0000); wr(6, 16'hFFFF);
    // R3 upper bits of run reg read 0
    wr(0, 16'hFFFC); rd_exp(0, 16'h0000, "R3 run upper bits");

    // R10 unmapped
    wr(7, 16'hFFFF);
    rd_exp(7, 16'h0000, "R10 unmapped read");
    rd_exp(0, 16'h0000, "R10 run reg unchanged");
    rd_exp(3, 16'hFFFF, "R10 cor0 unchanged");
    rd_exp(1, 16'h0000, "R10 ctl0 unchanged");

    // R8 stopped: counter equals compare with irq enabled
    base0 = irq_cnt0;
    wr(1, 16'h0040); wr(3, 16'h1234); wr(2, 16'h1234);
    repeat (600) @(posedge clk);
    rd_exp(2, 16'h1234, "R8 counter held");
    check(irq_cnt0 == base0, "R8 no irq when stopped", irq_cnt0 - base0, 0);

    // R5/R6/R7 cks=0 cor=3: period 32
    wr(1, 16'h0040); wr(3, 16'd3); wr(2, 16'd0); wr(0, 16'h0001);
    wait_irq(0, 100, n);
    check(n == 32, "R5 first match /8", n, 32);
    @(posedge clk); #1;
    check(irq_o[0] == 1'b0, "R7 pulse one clock", irq_o[0], 0);
    wait_irq(0, 100, n);
    check(n == 31, "R6 repeat period", n, 31);
    wr(0, 16'h0000);

    // R5 cks=1 cor=1: 2 ticks of 32
    wr(1, 16'h0041); wr(3, 16'd1); wr(2, 16'd0); wr(0, 16'h0001);
    wait_irq(0, 200, n);
    check(n == 64, "R5 divide by 32", n, 64);
    wr(0, 16'h0000);

    // R5 cks=2 cor=0
    wr(1, 16'h0042); wr(3, 16'd0); wr(2, 16'd0); wr(0, 16'h0001);
    wait_irq(0, 300, n);
    check(n == 128, "R5 divide by 128", n, 128);
    wr(0, 16'h0000);

    // R5 cks=3 cor=0
    wr(1, 16'h0043); wr(2, 16'd0); wr(0, 16'h0001);
    wait_irq(0, 1000, n);
    check(n == 512, "R5 divide by 512", n, 512);
    wr(0, 16'h0000);

    // R7 disabled interrupt, R11 live read, R6 wrap seen in value
    base0 = irq_cnt0;
    wr(1, 16'h0000); wr(3, 16'd3); wr(2, 16'd0); wr(0, 16'h0001);
    repeat (44) @(posedge clk);
    rd_exp(2, 16'd1, "R11 live counter after wrap");
    repeat (100) @(posedge clk);
    check(irq_cnt0 == base0, "R7 no irq with enable off", irq_cnt0 - base0, 0);
    wr(0, 16'h0000);

    // R9 counter write on the match edge
    wr(1, 16'h0040); wr(3, 16'd3); wr(2, 16'd0); wr(0, 16'h0001);
    repeat (31) @(posedge clk);
    wr(2, 16'd2);
    check(irq_o[0] == 1'b0, "R9 no irq on write edge", irq_o[0], 0);
    wait_irq(0, 100, n);
    check(n == 16, "R9 write wins over clear", n, 16);
    wr(0, 16'h0000);

    // R5 prescaler restart after mid-period stop
    wr(1, 16'h0000); wr(3, 16'hFFFF); wr(2, 16'd0); wr(0, 16'h0001);
    repeat (4) @(posedge clk);
    wr(0, 16'h0000);
    repeat (20) @(posedge clk);
    wr(0, 16'h0001);
    repeat (6) @(posedge clk);
    rd_exp(2, 16'd0, "R5 no early tick after restart");
    repeat (2) @(posedge clk);
    rd_exp(2, 16'd1, "R5 first tick after full period");
    wr(0, 16'h0000);

    // R3 both channels, independent rates
    wr(1, 16'h0040); wr(3, 16'd3); wr(2, 16'd0);
    wr(4, 16'h0041); wr(6, 16'd1); wr(5, 16'd0);
    base0 = irq_cnt0; base1 = irq_cnt1;
    wr(0, 16'h0003);
    rd_exp(0, 16'h0003, "R3 run readback");
    repeat (254) @(posedge clk);
    #2;
    check(irq_cnt0 - base0 == 7, "R3 ch0 irq count", irq_cnt0 - base0, 7);
    check(irq_cnt1 - base1 == 3, "R3 ch1 irq count", irq_cnt1 - base1, 3);
    wr(0, 16'h0000);

    repeat (4) @(posedge clk);
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule